// File: doc/BRIEF.md
# I2C LED Dimmer Register File

This block holds the register state of a sixteen-channel LED dimming controller placed behind an I2C target. A separate bit-level front end turns bus activity into single-cycle events (start, a received 7-bit address with its read/write flag, a received or delivered data byte, and stop). From those events the block decides whether the transfer is meant for it, takes the first written byte as a control byte, and then reads or writes registers at a moving pointer.

Its outputs feed the PWM generator and the output stage: one 8-bit duty value and one 2-bit output mode per channel, a group duty and group frequency value, and the control bits of the two mode registers. Duty values are written to a staging copy first. They reach the live outputs either at once or at the stop condition, as chosen by a mode bit. A broadcast address lets many devices share one write, and a reserved reset address with a two-byte key returns the block to its power-up state.

Top module: `led_dim_regs`

## Requirements
- R1: The block acknowledges reads and writes to address {110, strap_i}, unless strap_i is 4'h8 or 4'h0B. For those two strap values its own address is never used. Any other address is not acknowledged. addr_ack_o pulses in the cycle after addr_valid_i.
- R2: Address 0x68 is acknowledged for writes only, and only while MODE1 (register 0x00) bit 0 is set. Writes made through it act like writes to the block's own address.
- R3: In a write transfer the first data byte is the control byte. Bits 4:0 load the register pointer and bits 7:5 select auto-increment. MODE1 reads back those three bits in its bits 7:5, and writes to MODE1 bits 7:5 have no effect.
- R4: With control bit 7 set, the pointer advances after each byte within a window chosen by bits 6:5. The windows are 00: 0x00-0x17, 01: 0x02-0x11, 10: 0x12-0x17 and 11: 0x02-0x17. A pointer at the window's last register, or outside the window, moves to the window's first register.
- R5: With control bit 7 clear, the pointer never moves, so successive bytes overwrite the same register.
- R6: A read transfer returns the register at the pointer on rd_data_o, and each delivered byte advances the pointer as in R4/R5. A pointer of 0x18 or above reads 0, and a write there is ignored.
- R7: Registers 0x14-0x17 drive mode_o directly. Channel k takes bits 2(k%4)+1:2(k%4) of register 0x14+k/4, so mode_o[2k+1:2k] is channel k's mode.
- R8: Writes to 0x02-0x11 set the duty of channels 0-15. While MODE2 (0x01) bit 3 is clear, duty_o changes only at stop, and reads return the newly written (staged) value before then.
- R9: While MODE2 bit 3 is set, duty_o takes a written duty value in the same cycle as the byte write.
- R10: MODE1 bit 4 drives osc_off_o and bits 3:1 drive sub_en_o. MODE2 bit 5 drives blink_o. Writing 1 to MODE2 bit 7 gives a one-cycle err_clr_o pulse, and that bit always reads 0. MODE2 reads as {0,0,bit5,0,bit3,0,0,0}.
- R11: After rst_ni, MODE1 reads 0x11, so the oscillator is off and broadcast is enabled. All other registers and outputs are 0.
- R12: A write transfer to 0x6B (always acknowledged, reads never) carrying exactly the bytes 0xA5 then 0x5A and then a stop restores the R11 state. Any other byte sequence has no effect.
- R13: Data bytes of transfers not acknowledged by the block change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_i | input | 4 | Low address bits from strap pins |
| start_i | input | 1 | Start or repeated start seen |
| addr_valid_i | input | 1 | Address byte received this cycle |
| addr_i | input | 7 | Received 7-bit address |
| rnw_i | input | 1 | Read (1) or write (0) flag of the address |
| byte_valid_i | input | 1 | Data byte received (write) or delivered (read) |
| byte_i | input | 8 | Received data byte |
| stop_i | input | 1 | Stop seen |
| addr_ack_o | output | 1 | Address acknowledge, one cycle after addr_valid_i |
| rd_data_o | output | 8 | Register at the pointer, for the next read byte |
| duty_o | output | 128 | Live duty per channel, channel k at bits 8k+7:8k |
| mode_o | output | 32 | Output mode per channel, 2 bits each |
| grp_duty_o | output | 8 | Group duty register |
| grp_freq_o | output | 8 | Group frequency register |
| osc_off_o | output | 1 | Oscillator off, all outputs disabled |
| sub_en_o | output | 3 | Sub-address enables |
| blink_o | output | 1 | Group blinking selected instead of group dimming |
| err_clr_o | output | 1 | One-cycle error-flag clear pulse |

## Verification
The hardest situation to reach is a staged duty value that has been written but not yet committed. Only a transfer that has no stop can hold it, so the bench writes a duty byte and then reads it back through a repeated start in the same transfer. The read must return the new value while duty_o still shows the old one, and both must agree after the stop. The window wrap cases are reached by loading the pointer at the last register of each window, or past the register map, and then sending two bytes.

// File: rtl/led_dim_pkg.sv
package led_dim_pkg;
  typedef enum logic [1:0] {
    WIN_ALL    = 2'b00,
    WIN_PWM    = 2'b01,
    WIN_CTL    = 2'b10,
    WIN_PWMCTL = 2'b11
  } win_e;

  typedef enum logic [1:0] {
    KEY_IDLE  = 2'd0,
    KEY_HALF  = 2'd1,
    KEY_ARMED = 2'd2,
    KEY_BAD   = 2'd3
  } key_e;

  localparam logic [2:0] DEV_PREFIX = 3'b110;
  localparam logic [3:0] BCAST_LO   = 4'h8;
  localparam logic [3:0] SRST_LO    = 4'hB;
  localparam logic [7:0] SRST_KEY0  = 8'hA5;
  localparam logic [7:0] SRST_KEY1  = 8'h5A;
  localparam logic [4:0] MODE1_RST  = 5'h11;
endpackage

// File: rtl/led_dim_session.sv
module led_dim_session
  import led_dim_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] strap_i,
  input  logic       bcast_en_i,
  input  logic       start_i,
  input  logic       addr_valid_i,
  input  logic [6:0] addr_i,
  input  logic       rnw_i,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  input  logic       stop_i,
  output logic       ack_o,
  output logic       ctrl_ld_o,
  output logic       reg_wr_o,
  output logic       rd_adv_o,
  output logic       srst_o
);
  logic own_ok, hit_own, hit_bc, hit_sr;
  logic ack_q, wr_q, rd_q, sr_q, first_q;
  key_e key_q, key_d;

  assign own_ok  = (strap_i != BCAST_LO) && (strap_i != SRST_LO);
  assign hit_own = own_ok && (addr_i == {DEV_PREFIX, strap_i});
  assign hit_bc  = !rnw_i && bcast_en_i && (addr_i == {DEV_PREFIX, BCAST_LO});
  assign hit_sr  = !rnw_i && (addr_i == {DEV_PREFIX, SRST_LO});

  always_comb begin
    unique case (key_q)
      KEY_IDLE: key_d = (byte_i == SRST_KEY0) ? KEY_HALF : KEY_BAD;
      KEY_HALF: key_d = (byte_i == SRST_KEY1) ? KEY_ARMED : KEY_BAD;
      default:  key_d = KEY_BAD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      sr_q    <= 1'b0;
      first_q <= 1'b0;
      key_q   <= KEY_IDLE;
    end else begin
      ack_q <= addr_valid_i && (hit_own || hit_bc || hit_sr);
      if (start_i || stop_i) begin
        wr_q    <= 1'b0;
        rd_q    <= 1'b0;
        sr_q    <= 1'b0;
        first_q <= 1'b0;
        key_q   <= KEY_IDLE;
      end else if (addr_valid_i) begin
        wr_q    <= (hit_own || hit_bc) && !rnw_i;
        rd_q    <= hit_own && rnw_i;
        sr_q    <= hit_sr;
        first_q <= 1'b1;
        key_q   <= KEY_IDLE;
      end else if (byte_valid_i) begin
        if (wr_q) first_q <= 1'b0;
        if (sr_q) key_q <= key_d;
      end
    end
  end

  assign ack_o     = ack_q;
  assign ctrl_ld_o = byte_valid_i && wr_q && first_q;
  assign reg_wr_o  = byte_valid_i && wr_q && !first_q;
  assign rd_adv_o  = byte_valid_i && rd_q;
  assign srst_o    = stop_i && sr_q && (key_q == KEY_ARMED);

  assert_ack_after_addr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(addr_valid_i));
  assert_read_only_own_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o && $past(rnw_i) |-> $past(addr_i[3:0]) == $past(strap_i));
  assert_one_session_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_q, rd_q, sr_q}));
endmodule

// File: rtl/led_dim_ptr.sv
module led_dim_ptr
  import led_dim_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       soft_rst_i,
  input  logic       ctrl_ld_i,
  input  logic [7:0] ctrl_i,
  input  logic       adv_i,
  output logic [4:0] ptr_o,
  output logic [2:0] ai_o
);
  localparam int NLO    = NCH / 4;
  localparam int PWM_LO = 2;
  localparam int PWM_HI = NCH + 1;
  localparam int CTL_LO = NCH + 2;
  localparam int MAP_HI = NCH + 3 + NLO;

  logic [4:0] ptr_q, lo_c, hi_c, nxt_c;
  logic [2:0] ai_q;

  always_comb begin
    unique case (win_e'(ai_q[1:0]))
      WIN_ALL:    begin lo_c = 5'd0;         hi_c = 5'(MAP_HI); end
      WIN_PWM:    begin lo_c = 5'(PWM_LO);   hi_c = 5'(PWM_HI); end
      WIN_CTL:    begin lo_c = 5'(CTL_LO);   hi_c = 5'(MAP_HI); end
      default:    begin lo_c = 5'(PWM_LO);   hi_c = 5'(MAP_HI); end
    endcase
    nxt_c = (ptr_q < lo_c || ptr_q >= hi_c) ? lo_c : ptr_q + 5'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      ai_q  <= '0;
    end else if (soft_rst_i) begin
      ptr_q <= '0;
      ai_q  <= '0;
    end else if (ctrl_ld_i) begin
      ptr_q <= ctrl_i[4:0];
      ai_q  <= ctrl_i[7:5];
    end else if (adv_i && ai_q[2]) begin
      ptr_q <= nxt_c;
    end
  end

  assign ptr_o = ptr_q;
  assign ai_o  = ai_q;

  assert_fixed_ptr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !ai_q[2] && !ctrl_ld_i && !soft_rst_i |=> $stable(ptr_q));
  assert_pwm_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && ai_q == 3'b101 && !ctrl_ld_i && !soft_rst_i |=>
      ptr_q >= 5'(PWM_LO) && ptr_q <= 5'(PWM_HI));
  assert_ctl_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && ai_q == 3'b110 && !ctrl_ld_i && !soft_rst_i |=>
      ptr_q >= 5'(CTL_LO) && ptr_q <= 5'(MAP_HI));
endmodule

// File: rtl/led_dim_bank.sv
module led_dim_bank
  import led_dim_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           soft_rst_i,
  input  logic           wr_i,
  input  logic [4:0]     ptr_i,
  input  logic [7:0]     data_i,
  input  logic [2:0]     ai_i,
  input  logic           stop_i,
  output logic [7:0]     rd_data_o,
  output logic [NCH*8-1:0] duty_o,
  output logic [NCH*2-1:0] mode_o,
  output logic [7:0]     grp_duty_o,
  output logic [7:0]     grp_freq_o,
  output logic           osc_off_o,
  output logic [2:0]     sub_en_o,
  output logic           bcast_en_o,
  output logic           blink_o,
  output logic           err_clr_o
);
  localparam int NLO    = NCH / 4;
  localparam int PWM_LO = 2;
  localparam int PWM_HI = NCH + 1;
  localparam int GDUTY  = NCH + 2;
  localparam int GFREQ  = NCH + 3;
  localparam int LO_LO  = NCH + 4;
  localparam int LO_HI  = NCH + 3 + NLO;

  logic [4:0]         mode1_q;
  logic               blink_q, och_q, errc_q;
  logic [7:0]         gduty_q, gfreq_q;
  logic [NCH*8-1:0]   stage_flat;
  logic [NLO*8-1:0]   lo_flat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode1_q <= MODE1_RST;
      blink_q <= 1'b0;
      och_q   <= 1'b0;
      errc_q  <= 1'b0;
      gduty_q <= '0;
      gfreq_q <= '0;
    end else if (soft_rst_i) begin
      mode1_q <= MODE1_RST;
      blink_q <= 1'b0;
      och_q   <= 1'b0;
      errc_q  <= 1'b0;
      gduty_q <= '0;
      gfreq_q <= '0;
    end else begin
      errc_q <= 1'b0;
      if (wr_i) begin
        if (ptr_i == 5'd0) mode1_q <= data_i[4:0];
        if (ptr_i == 5'd1) begin
          errc_q  <= data_i[7];
          blink_q <= data_i[5];
          och_q   <= data_i[3];
        end
        if (ptr_i == 5'(GDUTY)) gduty_q <= data_i;
        if (ptr_i == 5'(GFREQ)) gfreq_q <= data_i;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic       hit;
    logic [7:0] stage_q, live_q;
    assign hit = wr_i && (ptr_i == 5'(PWM_LO + c));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q <= '0;
        live_q  <= '0;
      end else if (soft_rst_i) begin
        stage_q <= '0;
        live_q  <= '0;
      end else begin
        if (hit) stage_q <= data_i;
        if (hit && och_q) live_q <= data_i;
        else if (stop_i)  live_q <= stage_q;
      end
    end
    assign stage_flat[c*8 +: 8] = stage_q;
    assign duty_o[c*8 +: 8]     = live_q;
  end

  for (genvar r = 0; r < NLO; r++) begin : g_lo
    logic [7:0] lo_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                lo_q <= '0;
      else if (soft_rst_i)                        lo_q <= '0;
      else if (wr_i && ptr_i == 5'(LO_LO + r))    lo_q <= data_i;
    end
    assign lo_flat[r*8 +: 8] = lo_q;
  end

  always_comb begin
    rd_data_o = '0;
    if (ptr_i == 5'd0)
      rd_data_o = {ai_i, mode1_q};
    else if (ptr_i == 5'd1)
      rd_data_o = {2'b00, blink_q, 1'b0, och_q, 3'b000};
    else if (ptr_i >= 5'(PWM_LO) && ptr_i <= 5'(PWM_HI))
      rd_data_o = stage_flat[(int'(ptr_i) - PWM_LO)*8 +: 8];
    else if (ptr_i == 5'(GDUTY))
      rd_data_o = gduty_q;
    else if (ptr_i == 5'(GFREQ))
      rd_data_o = gfreq_q;
    else if (ptr_i >= 5'(LO_LO) && ptr_i <= 5'(LO_HI))
      rd_data_o = lo_flat[(int'(ptr_i) - LO_LO)*8 +: 8];
  end

  assign mode_o     = lo_flat;
  assign grp_duty_o = gduty_q;
  assign grp_freq_o = gfreq_q;
  assign osc_off_o  = mode1_q[4];
  assign sub_en_o   = mode1_q[3:1];
  assign bcast_en_o = mode1_q[0];
  assign blink_o    = blink_q;
  assign err_clr_o  = errc_q;

  assert_staged_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !och_q && !stop_i && !soft_rst_i |=> $stable(duty_o));
  assert_errclr_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_o |-> $past(wr_i) && $past(ptr_i) == 5'd1);
  assert_srst_osc_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> osc_off_o && bcast_en_o && grp_duty_o == 8'h00);
endmodule

// File: rtl/led_dim_regs.sv
module led_dim_regs
  import led_dim_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       strap_i,
  input  logic             start_i,
  input  logic             addr_valid_i,
  input  logic [6:0]       addr_i,
  input  logic             rnw_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  input  logic             stop_i,
  output logic             addr_ack_o,
  output logic [7:0]       rd_data_o,
  output logic [NCH*8-1:0] duty_o,
  output logic [NCH*2-1:0] mode_o,
  output logic [7:0]       grp_duty_o,
  output logic [7:0]       grp_freq_o,
  output logic             osc_off_o,
  output logic [2:0]       sub_en_o,
  output logic             blink_o,
  output logic             err_clr_o
);
  logic       bcast_en, ctrl_ld, reg_wr, rd_adv, srst;
  logic [4:0] ptr;
  logic [2:0] ai;

  led_dim_session u_sess (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .strap_i      (strap_i),
    .bcast_en_i   (bcast_en),
    .start_i      (start_i),
    .addr_valid_i (addr_valid_i),
    .addr_i       (addr_i),
    .rnw_i        (rnw_i),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .stop_i       (stop_i),
    .ack_o        (addr_ack_o),
    .ctrl_ld_o    (ctrl_ld),
    .reg_wr_o     (reg_wr),
    .rd_adv_o     (rd_adv),
    .srst_o       (srst)
  );

  led_dim_ptr #(.NCH(NCH)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (srst),
    .ctrl_ld_i  (ctrl_ld),
    .ctrl_i     (byte_i),
    .adv_i      (reg_wr || rd_adv),
    .ptr_o      (ptr),
    .ai_o       (ai)
  );

  led_dim_bank #(.NCH(NCH)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (srst),
    .wr_i       (reg_wr),
    .ptr_i      (ptr),
    .data_i     (byte_i),
    .ai_i       (ai),
    .stop_i     (stop_i),
    .rd_data_o  (rd_data_o),
    .duty_o     (duty_o),
    .mode_o     (mode_o),
    .grp_duty_o (grp_duty_o),
    .grp_freq_o (grp_freq_o),
    .osc_off_o  (osc_off_o),
    .sub_en_o   (sub_en_o),
    .bcast_en_o (bcast_en),
    .blink_o    (blink_o),
    .err_clr_o  (err_clr_o)
  );

  assert_ctrl_mirror_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_ld && !srst |=> rd_data_o[7:5] == $past(byte_i[7:5]) || ptr != 5'd0);
endmodule

// File: tb/led_dim_regs_test.sv
module led_dim_regs_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   strap = 4'h5;
  logic         start = 1'b0, av = 1'b0, rnw = 1'b0, bv = 1'b0, stop = 1'b0;
  logic [6:0]   addr = '0;
  logic [7:0]   bdat = '0;
  logic         ack;
  logic [7:0]   rd_data, gduty, gfreq;
  logic [127:0] duty;
  logic [31:0]  mode;
  logic         osc_off, blink, errc;
  logic [2:0]   sub_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] wbuf [0:7];
  logic       a_got;
  logic [7:0] r_got;

  localparam logic [6:0] OWN = 7'h65;

  always #5 clk = ~clk;

  led_dim_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap), .start_i(start),
    .addr_valid_i(av), .addr_i(addr), .rnw_i(rnw), .byte_valid_i(bv),
    .byte_i(bdat), .stop_i(stop), .addr_ack_o(ack), .rd_data_o(rd_data),
    .duty_o(duty), .mode_o(mode), .grp_duty_o(gduty), .grp_freq_o(gfreq),
    .osc_off_o(osc_off), .sub_en_o(sub_en), .blink_o(blink), .err_clr_o(errc)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start; @(negedge clk) start = 1; @(negedge clk) start = 0; endtask
  task automatic do_stop;  @(negedge clk) stop = 1;  @(negedge clk) stop = 0;  endtask
  task automatic do_byte(input logic [7:0] b);
    @(negedge clk) bdat = b; bv = 1; @(negedge clk) bv = 0;
  endtask
  task automatic do_addr(input logic [6:0] a, input logic r, output logic got);
    @(negedge clk) addr = a; rnw = r; av = 1; @(negedge clk) av = 0; got = ack;
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] ctrl, input int n, output logic got);
    do_start;
    do_addr(a, 1'b0, got);
    do_byte(ctrl);
    for (int i = 0; i < n; i++) do_byte(wbuf[i]);
    do_stop;
  endtask

  task automatic rd_reg(input logic [4:0] p, output logic [7:0] v);
    logic g;
    do_start;
    do_addr(OWN, 1'b0, g);
    do_byte({3'b000, p});
    do_start;
    do_addr(OWN, 1'b1, g);
    v = rd_data;
    do_stop;
  endtask

  task automatic t_reset;
    chk("R11 duty", duty[63:0], 64'h0);
    chk("R11 mode", {32'h0, mode}, 64'h0);
    chk("R11 osc_off", osc_off, 1);
    rd_reg(5'h00, r_got); chk("R11 MODE1", r_got, 8'h11);
    rd_reg(5'h12, r_got); chk("R11 GRPPWM", r_got, 8'h00);
    rd_reg(5'h01, r_got); chk("R11 MODE2", r_got, 8'h00);
  endtask

  task automatic t_ctrl_mirror;
    logic g;
    wr_txn(OWN, 8'hA0, 0, g);
    do_start; do_addr(OWN, 1'b1, g);
    chk("R3 mirror", rd_data, 8'hB1);
    do_stop;
    wbuf[0] = 8'hF1;
    wr_txn(OWN, 8'h00, 1, g);
    rd_reg(5'h00, r_got); chk("R3 MODE1 7:5 ignored", r_got, 8'h11);
  endtask

  task automatic t_addr;
    logic g;
    do_start; do_addr(OWN, 1'b0, g); chk("R1 own write ack", g, 1); do_stop;
    do_start; do_addr(OWN, 1'b1, g); chk("R1 own read ack", g, 1); do_stop;
    do_start; do_addr(7'h66, 1'b0, g); chk("R1 other no ack", g, 0); do_stop;
    strap = 4'h8;
    do_start; do_addr(7'h68, 1'b1, g); chk("R1 strap 8 read no ack", g, 0); do_stop;
    strap = 4'hB;
    do_start; do_addr(7'h6B, 1'b1, g); chk("R1 strap 11 read no ack", g, 0); do_stop;
    strap = 4'h5;
    do_start; do_addr(7'h6B, 1'b1, g); chk("R12 srst read no ack", g, 0); do_stop;
    wbuf[0] = 8'h99;
    wr_txn(7'h66, 8'h12, 1, g);
    rd_reg(5'h12, r_got); chk("R13 foreign write ignored", r_got, 8'h00);
  endtask

  task automatic t_bcast;
    logic g;
    wbuf[0] = 8'h44;
    wr_txn(7'h68, 8'h13, 1, g);
    chk("R2 bcast ack", g, 1);
    chk("R2 bcast write", gfreq, 8'h44);
    wbuf[0] = 8'h10; wr_txn(OWN, 8'h00, 1, g);
    wbuf[0] = 8'h55; wr_txn(7'h68, 8'h13, 1, g);
    chk("R2 bcast disabled no ack", g, 0);
    chk("R2 bcast disabled no write", gfreq, 8'h44);
    wbuf[0] = 8'h11; wr_txn(OWN, 8'h00, 1, g);
  endtask

  task automatic t_windows;
    logic g;
    wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h01;
    wr_txn(OWN, 8'h96, 3, g);
    chk("R4 all-window wrap to MODE1", osc_off, 0);
    chk("R4 all-window LEDOUT2", mode[17:16], 2'd1);
    chk("R4 all-window LEDOUT3", mode[25:24], 2'd2);
    wbuf[0] = 8'h5A; wbuf[1] = 8'h33;
    wr_txn(OWN, 8'hB1, 2, g);
    chk("R4 pwm window last", duty[127:120], 8'h5A);
    chk("R4 pwm window wrap", duty[7:0], 8'h33);
    wbuf[0] = 8'hFF; wbuf[1] = 8'h77;
    wr_txn(OWN, 8'hD7, 2, g);
    chk("R4 ctl window last", mode[31:24], 8'hFF);
    chk("R4 ctl window wrap", gduty, 8'h77);
    wbuf[0] = 8'h00; wbuf[1] = 8'h44;
    wr_txn(OWN, 8'hF7, 2, g);
    chk("R4 pwm+ctl window last", mode[31:24], 8'h00);
    chk("R4 pwm+ctl window wrap", duty[7:0], 8'h44);
  endtask

  task automatic t_fixed;
    logic g;
    wbuf[0] = 8'h10; wbuf[1] = 8'h20;
    wr_txn(OWN, 8'h05, 2, g);
    chk("R5 same register overwritten", duty[31:24], 8'h20);
    chk("R5 next register untouched", duty[39:32], 8'h00);
  endtask

  task automatic t_read;
    logic g;
    do_start; do_addr(OWN, 1'b0, g); do_byte(8'h82);
    do_start; do_addr(OWN, 1'b1, g);
    chk("R6 read PWM0", rd_data, 8'h44);
    do_byte(8'h00); do_byte(8'h00); do_byte(8'h00);
    chk("R6 read advance to PWM3", rd_data, 8'h20);
    do_stop;
    do_start; do_addr(OWN, 1'b0, g); do_byte(8'h9A); do_byte(8'h66);
    do_start; do_addr(OWN, 1'b1, g);
    chk("R6 out-of-map write ignored, pointer wrapped", rd_data, 8'h81);
    do_stop;
    do_start; do_addr(OWN, 1'b0, g); do_byte(8'h9A);
    do_start; do_addr(OWN, 1'b1, g);
    chk("R6 out-of-map reads zero", rd_data, 8'h00);
    do_stop;
  endtask

  task automatic t_ledout;
    logic g;
    wbuf[0] = 8'hE4; wbuf[1] = 8'h1B;
    wr_txn(OWN, 8'h94, 2, g);
    chk("R7 ch1 mode", mode[3:2], 2'd1);
    chk("R7 ch3 mode", mode[7:6], 2'd3);
    chk("R7 ch4 mode", mode[9:8], 2'd3);
    chk("R7 ch7 mode", mode[15:14], 2'd0);
  endtask

  task automatic t_staged;
    logic g;
    do_start; do_addr(OWN, 1'b0, g); do_byte(8'h07); do_byte(8'h9C);
    chk("R8 duty held before stop", duty[47:40], 8'h00);
    do_start; do_addr(OWN, 1'b1, g);
    chk("R8 staged readback", rd_data, 8'h9C);
    chk("R8 duty held across repeated start", duty[47:40], 8'h00);
    do_stop;
    chk("R8 duty committed at stop", duty[47:40], 8'h9C);
  endtask

  task automatic t_on_ack;
    logic g;
    wbuf[0] = 8'h08; wr_txn(OWN, 8'h01, 1, g);
    do_start; do_addr(OWN, 1'b0, g); do_byte(8'h08); do_byte(8'h3C);
    chk("R9 duty on byte", duty[55:48], 8'h3C);
    do_stop;
  endtask

  task automatic t_mode_bits;
    logic g;
    wbuf[0] = 8'h0F; wr_txn(OWN, 8'h00, 1, g);
    chk("R10 sub_en", sub_en, 3'b111);
    chk("R10 osc on", osc_off, 0);
    do_start; do_addr(OWN, 1'b0, g); do_byte(8'h01); do_byte(8'hA8);
    chk("R10 err_clr pulse", errc, 1);
    @(negedge clk);
    chk("R10 err_clr one cycle", errc, 0);
    do_stop;
    chk("R10 blink", blink, 1);
    rd_reg(5'h01, r_got); chk("R10 MODE2 readback", r_got, 8'h28);
  endtask

  task automatic t_srst;
    logic g;
    wbuf[0] = 8'h00; wr_txn(7'h6B, 8'hA5, 1, g);
    chk("R12 srst ack", g, 1);
    chk("R12 bad key no effect", gduty, 8'h77);
    wbuf[0] = 8'h5A; wbuf[1] = 8'h5A; wr_txn(7'h6B, 8'hA5, 2, g);
    chk("R12 extra byte no effect", gduty, 8'h77);
    wbuf[0] = 8'h5A; wr_txn(7'h6B, 8'hA5, 1, g);
    chk("R12 reset grp", gduty, 8'h00);
    chk("R12 reset duty", duty[63:0], 64'h0);
    chk("R12 reset osc", osc_off, 1);
    chk("R12 reset blink", blink, 0);
    rd_reg(5'h00, r_got); chk("R12 MODE1", r_got, 8'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_ctrl_mirror;
    t_addr;
    t_bcast;
    t_windows;
    t_fixed;
    t_read;
    t_ledout;
    t_staged;
    t_on_ack;
    t_mode_bits;
    t_srst;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule